// File: doc/BRIEF.md
# PIO Activity Latch Bank

This block keeps one sticky activity flag for each general-purpose I/O channel. A flag goes high when its pin moves to a new level and holds that level for at least a programmable number of clock cycles. Shorter excursions are treated as glitches and ignored. The cause of the level change does not matter. It can be an outside signal, an update of the pin's output register, or a pulse generated on the chip. Any of these counts once it is long enough. Each raw pin level passes through a two-flop synchronizer before the width filter sees it.

Software cannot write the flags. The only way to clear them is a dedicated command byte, C3h. When that byte arrives from the serial-bus command decoder while the controller is waiting for a command, every flag clears on the same clock edge. The controller then enters a confirmation phase. In that phase every byte the bus master reads is answered with AAh, until a bus-reset pulse returns the controller to waiting for commands. The master can also confirm the clear through the register read port, at the status address (default 0222h). That read returns the flag vector.

A small state machine runs the command flow. Its states are CMD_IDLE (waiting for a command) and CMD_CONFIRM (answering reads with the confirmation byte). The transitions are:
- CMD_IDLE to CMD_CONFIRM on an accepted clear command.
- CMD_CONFIRM to CMD_IDLE on bus reset.
- In every other case the state holds.

Top module: `pio_activity_bank`

## Requirements
- R1: After reset, `latch_q` is all zero, `conf_valid` and `reg_rvalid` are low, and the controller is in CMD_IDLE. The filtered reference level of every pin starts low.
- R2: A change of `pin_raw[i]` in either direction that is held for MIN_PULSE or more consecutive clock cycles sets `latch_q[i]`. The bit becomes visible MIN_PULSE+2 rising edges after the pin changes: two edges for synchronization and MIN_PULSE edges for qualification.
- R3: A pin excursion that returns to its previous level in fewer than MIN_PULSE cycles does not set the latch.
- R4: The channels are independent. A set flag stays set through later pin activity and through bus resets, until a clear command arrives.
- R5: When `cmd_valid` is high with `cmd_byte` = C3h in CMD_IDLE and `bus_reset` is low, every flag clears on that edge and the state moves to CMD_CONFIRM. Any other command code changes neither the flags nor the state.
- R6: If a qualifying transition completes on the same edge as an accepted clear command, the clear wins and the flag stays low.
- R7: In CMD_CONFIRM, each `rd_req` makes `conf_valid` high for one cycle on the next cycle, with `conf_byte` = AAh. In CMD_IDLE, `rd_req` produces no `conf_valid`. In CMD_CONFIRM, `cmd_valid` is ignored.
- R8: `bus_reset` returns the controller to CMD_IDLE and leaves the flags unchanged. In the same cycle, `bus_reset` takes priority over both `rd_req` and a clear command: neither is acted on.
- R9: `reg_rd` with `reg_addr` = STATUS_ADDR (default 0222h) returns the flags one cycle later on `reg_rdata`, with bit i = channel i and the upper bits zero, and with `reg_rvalid` high. Any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NCH | Unsynchronized pin levels |
| cmd_byte | input | 8 | Decoded command code |
| cmd_valid | input | 1 | Strobe for cmd_byte |
| bus_reset | input | 1 | Serial-bus reset pulse |
| rd_req | input | 1 | Master byte-read request |
| conf_valid | output | 1 | Confirmation byte valid |
| conf_byte | output | 8 | Confirmation byte (AAh) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register read address |
| reg_rvalid | output | 1 | Register read data valid |
| reg_rdata | output | DATA_W | Register read data |
| latch_q | output | NCH | Activity flag vector |

## Verification
A pin change applied just after a falling clock edge shows up on `latch_q` exactly MIN_PULSE+2 rising edges later. The bench samples the flags one falling edge before that point, where they must still be low, and again at that point, where they must be set. A clear command is reflected on `latch_q` at the first falling edge after the command's rising edge. The confirmation byte and the register read data are both due one cycle after their request. The driver pushes each expected reply into a queue before raising the request, and a monitor on the falling edges pops an entry only when a valid strobe appears. The clear-versus-qualify race is staged by raising the command on the falling edge just before the qualifying rising edge.

// File: rtl/pio_act_pkg.sv
package pio_act_pkg;

    typedef enum logic [0:0] {
        CMD_IDLE    = 1'b0,
        CMD_CONFIRM = 1'b1
    } cmd_state_e;

    localparam logic [7:0] CLR_OPCODE   = 8'hC3;
    localparam logic [7:0] CONFIRM_BYTE = 8'hAA;

endpackage

// File: rtl/pio_act_sync.sv
module pio_act_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end

endmodule

// File: rtl/pio_act_qual.sv
module pio_act_qual #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic hit
);

    localparam int CNT_W = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PULSE - 1);

    logic             ref_lvl;
    logic [CNT_W-1:0] run_cnt;
    logic             differs;

    assign differs = (lvl != ref_lvl);
    assign hit     = differs && (run_cnt == LAST);

    // The new level must persist for MIN_PULSE samples before it becomes
    // the reference; any return to the reference level restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_lvl <= 1'b0;
            run_cnt <= '0;
        end else if (differs) begin
            if (run_cnt == LAST) begin
                ref_lvl <= lvl;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

endmodule

// File: rtl/pio_act_ctrl.sv
module pio_act_ctrl
    import pio_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_valid,
    input  logic       bus_reset,
    input  logic       rd_req,
    output logic       clear_all,
    output logic       in_confirm,
    output logic       conf_valid,
    output logic [7:0] conf_byte
);

    cmd_state_e state_q, state_d;
    logic       serve_rd;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    // Next state and command decode
    always_comb begin
        state_d   = state_q;
        clear_all = 1'b0;
        serve_rd  = 1'b0;
        unique case (state_q)
            CMD_IDLE: begin
                if (!bus_reset && cmd_valid && cmd_byte == CLR_OPCODE) begin
                    clear_all = 1'b1;
                    state_d   = CMD_CONFIRM;
                end
            end
            CMD_CONFIRM: begin
                if (bus_reset) state_d = CMD_IDLE;
                else           serve_rd = rd_req;
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    assign in_confirm = (state_q == CMD_CONFIRM);

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conf_valid <= 1'b0;
            conf_byte  <= 8'h00;
        end else begin
            conf_valid <= serve_rd;
            conf_byte  <= serve_rd ? CONFIRM_BYTE : 8'h00;
        end
    end

endmodule

// File: rtl/pio_act_regport.sv
module pio_act_regport #(
    parameter int              NCH         = 2,
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0222
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NCH-1:0]    flags,
    output logic              reg_rvalid,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word          = '0;
        status_word[NCH-1:0] = flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd && reg_addr == STATUS_ADDR) reg_rdata <= status_word;
            else                                   reg_rdata <= '0;
        end
    end

endmodule

// File: rtl/pio_activity_bank.sv
module pio_activity_bank #(
    parameter int                NCH         = 2,
    parameter int                MIN_PULSE   = 4,
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0222
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_raw,
    input  logic [7:0]        cmd_byte,
    input  logic              cmd_valid,
    input  logic              bus_reset,
    input  logic              rd_req,
    output logic              conf_valid,
    output logic [7:0]        conf_byte,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rvalid,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    latch_q
);

    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] set_vec;
    logic           clear_all;
    logic           mode_confirm;

    pio_act_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .d_sync  (pin_sync)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pio_act_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_sync[ch]),
            .hit   (set_vec[ch])
        );

        // Clear outranks a coincident qualification
        always_ff @(posedge clk) begin
            if (!rst_n)         latch_q[ch] <= 1'b0;
            else if (clear_all) latch_q[ch] <= 1'b0;
            else if (set_vec[ch]) latch_q[ch] <= 1'b1;
        end
    end

    pio_act_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_byte   (cmd_byte),
        .cmd_valid  (cmd_valid),
        .bus_reset  (bus_reset),
        .rd_req     (rd_req),
        .clear_all  (clear_all),
        .in_confirm (mode_confirm),
        .conf_valid (conf_valid),
        .conf_byte  (conf_byte)
    );

    pio_act_regport #(
        .NCH         (NCH),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .flags      (latch_q),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata)
    );

endmodule

// File: rtl/pio_activity_bank_chk.sv
module pio_activity_bank_chk #(
    parameter int                NCH         = 2,
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0222
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        cmd_byte,
    input logic              cmd_valid,
    input logic              bus_reset,
    input logic              rd_req,
    input logic              conf_valid,
    input logic [7:0]        conf_byte,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rvalid,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NCH-1:0]    latch_q,
    input logic              in_confirm
);

    logic clr_cmd;
    assign clr_cmd = cmd_valid && cmd_byte == 8'hC3 && !bus_reset && !in_confirm;

    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (latch_q == '0));

    a_r5_enter_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> in_confirm);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    a_r7_conf_value: assert property (@(posedge clk) disable iff (!rst_n)
        conf_valid |-> (conf_byte == 8'hAA));

    a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_confirm) |=> !conf_valid);

    a_r8_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !in_confirm);

    a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_reset) |=> !conf_valid);

    a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == STATUS_ADDR) |=>
            (reg_rvalid && reg_rdata == DATA_W'($past(latch_q))));

endmodule

bind pio_activity_bank pio_activity_bank_chk #(
    .NCH         (NCH),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_byte   (cmd_byte),
    .cmd_valid  (cmd_valid),
    .bus_reset  (bus_reset),
    .rd_req     (rd_req),
    .conf_valid (conf_valid),
    .conf_byte  (conf_byte),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .latch_q    (latch_q),
    .in_confirm (mode_confirm)
);

// File: tb/test_pio_activity_bank.sv
`timescale 1ns/1ps
module test_pio_activity_bank;

    localparam int NCH  = 2;
    localparam int MINP = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   pin_raw = '0;
    logic [7:0]       cmd_byte = 8'h00;
    logic             cmd_valid = 1'b0;
    logic             bus_reset = 1'b0;
    logic             rd_req = 1'b0;
    logic             conf_valid;
    logic [7:0]       conf_byte;
    logic             reg_rd = 1'b0;
    logic [15:0]      reg_addr = 16'h0000;
    logic             reg_rvalid;
    logic [7:0]       reg_rdata;
    logic [NCH-1:0]   latch_q;

    always #2 clk = ~clk;

    pio_activity_bank #(.NCH(NCH), .MIN_PULSE(MINP)) i_pio_activity_bank (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .bus_reset(bus_reset),
        .rd_req(rd_req), .conf_valid(conf_valid), .conf_byte(conf_byte),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .latch_q(latch_q)
    );

    typedef struct {
        bit         is_reg;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t           sb_q[$];
    int             n_chk = 0;
    int             n_bad = 0;
    bit             done  = 1'b0;
    logic [NCH-1:0] exp_latch = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nstep(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (conf_valid || reg_rvalid)) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R7: unexpected reply conf=%0h reg=%0h expected none",
                         conf_byte, reg_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.is_reg) chk({e.tag, " reg read"}, {reg_rvalid, reg_rdata}, {1'b1, e.data});
                else          chk({e.tag, " confirm"}, {conf_valid, conf_byte}, {1'b1, e.data});
            end
        end
    end

    task automatic reg_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.is_reg = 1'b1; e.data = exp; e.tag = tag;
        sb_q.push_back(e);
        reg_addr = a; reg_rd = 1'b1;
        nstep(1);
        reg_rd = 1'b0;
    endtask

    task automatic conf_read(input bit expect_reply, input string tag);
        if (expect_reply) begin
            exp_t e;
            e.is_reg = 1'b0; e.data = 8'hAA; e.tag = tag;
            sb_q.push_back(e);
        end
        rd_req = 1'b1;
        nstep(1);
        rd_req = 1'b0;
        if (!expect_reply) chk({tag, " no reply"}, conf_valid, 0);
    endtask

    task automatic send_cmd(input logic [7:0] code);
        cmd_byte = code; cmd_valid = 1'b1;
        nstep(1);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_bus_reset();
        bus_reset = 1'b1;
        nstep(1);
        bus_reset = 1'b0;
    endtask

    // Hold a new level and check the flag timing (R2)
    task automatic qualify(input int ch, input logic lvl);
        pin_raw[ch] = lvl;
        nstep(MINP + 1);
        chk("R2 before width", latch_q, exp_latch);
        nstep(1);
        exp_latch[ch] = 1'b1;
        chk("R2 after width", latch_q, exp_latch);
    endtask

    initial begin
        nstep(5);
        rst_n = 1'b1;
        nstep(1);
        // R1
        chk("R1 latch", latch_q, 0);
        chk("R1 conf_valid", conf_valid, 0);
        chk("R1 reg_rvalid", reg_rvalid, 0);
        reg_read(16'h0222, 8'h00, "R9 after reset");
        reg_read(16'h0223, 8'h00, "R9 other addr");
        conf_read(1'b0, "R1 idle read");

        // R3: glitch one cycle short of the width
        pin_raw[0] = 1'b1;
        nstep(MINP - 1);
        pin_raw[0] = 1'b0;
        nstep(MINP + 4);
        chk("R3 glitch", latch_q, 0);

        // R2 rising, R4 independence
        qualify(0, 1'b1);
        chk("R4 ch1 untouched", latch_q[1], 0);
        pin_raw[0] = 1'b0;
        nstep(MINP + 4);
        chk("R4 stays set", latch_q, exp_latch);
        qualify(1, 1'b1);

        // R5: other code ignored
        send_cmd(8'h3C);
        chk("R5 other code", latch_q, 2'b11);
        conf_read(1'b0, "R5 other code mode");

        // R8: bus reset keeps flags
        pulse_bus_reset();
        chk("R8 flags kept idle", latch_q, 2'b11);
        reg_read(16'h0222, 8'h03, "R9 both set");

        // R5 clear
        send_cmd(8'hC3);
        exp_latch = '0;
        chk("R5 cleared", latch_q, 0);
        reg_read(16'h0222, 8'h00, "R5 status after clear");

        // R7 back-to-back confirmation reads
        conf_read(1'b1, "R7 read1");
        conf_read(1'b1, "R7 read2");
        begin
            exp_t e;
            e.is_reg = 1'b0; e.data = 8'hAA; e.tag = "R7 burst";
            sb_q.push_back(e); sb_q.push_back(e);
            rd_req = 1'b1;
            nstep(2);
            rd_req = 1'b0;
        end
        send_cmd(8'h55);
        conf_read(1'b1, "R7 cmd ignored");

        // R2 falling transition while confirming
        qualify(1, 1'b0);

        // R8: bus reset with read in the same cycle
        rd_req = 1'b1; bus_reset = 1'b1;
        nstep(1);
        rd_req = 1'b0; bus_reset = 1'b0;
        chk("R8 reset wins read", conf_valid, 0);
        chk("R8 flags kept", latch_q, 2'b10);
        conf_read(1'b0, "R8 back to idle");

        // R6: clear coincides with qualification on ch0
        send_cmd(8'hC3);
        exp_latch = '0;
        chk("R6 pre", latch_q, 0);
        pin_raw[0] = 1'b1;
        nstep(MINP + 1);
        cmd_byte = 8'hC3; cmd_valid = 1'b1;
        pulse_bus_reset();
        cmd_valid = 1'b0;
        pulse_bus_reset();
        // the above staged reset-with-command; redo race in idle
        pin_raw[0] = 1'b0;
        nstep(MINP + 4);
        exp_latch = latch_q;
        chk("R8 reset beats clear", latch_q, 2'b01);
        exp_latch = 2'b01;
        conf_read(1'b0, "R8 clear not taken");

        pin_raw[1] = 1'b1;
        nstep(MINP + 1);
        cmd_byte = 8'hC3; cmd_valid = 1'b1;
        nstep(1);
        cmd_valid = 1'b0;
        chk("R6 clear wins", latch_q, 0);
        nstep(MINP + 3);
        chk("R6 stays clear", latch_q, 0);
        conf_read(1'b1, "R6 in confirm");
        pulse_bus_reset();

        nstep(4);
        chk("R7 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule